// File: doc/BRIEF.md
# Iterative bfloat16 Shift-Add Multiplier

This block multiplies two bfloat16 numbers over several clock cycles. The block captures both 16-bit operands when a start request arrives while it is idle. It sets the result sign to the exclusive-or of the operand signs. It sets the exponent to the sum of the two biased exponents with one bias of 127 removed. The block builds the significand product with one conditional shift-add per clock.

Each significand has its hidden one restored and is aligned inside a 32-bit word. A mask walks the bits of the first significand from the most significant bit down. The accumulator adds a right-shifting copy of the second significand for every set bit. When the eight steps are done, the block normalises the product by a shift of one or two bits, chosen by the product's top bit. It then rounds half-up to seven mantissa bits and packs the result. Busy is high while the block works. A one-cycle done pulse marks a new result, and the result stays on its port until the next one. Zero, infinity, NaN and subnormal operands are not handled, and the block raises no range flags.

Top module: `bf16_shift_add_mul`

## Requirements
- R1: The result sign, bit 15 of `result`, is the exclusive-or of bit 15 of `op_a` and bit 15 of `op_b`.
- R2: With exponent fields at bits 14:7 and mantissas at bits 6:0, the result exponent is ea + eb − 127, plus any normalisation or rounding increment.
- R3: The 16-bit product P = {1,ma}·{1,mb} is formed. When bit 15 of P is set, the exponent rises by one and the eight rounding bits are P[14:7]. For example, 0x4142 × 0x4236 gives 0x440A.
- R4: When bit 15 of P is clear, the exponent is unchanged and the eight rounding bits are P[13:6]. For example, 0x3F80 × 0x3F80 gives 0x3F80.
- R5: Rounding is half-up. The mantissa field receives (H + 1) >> 1, where H is the 8-bit value taken from P.
- R6: A rounding result of 128 is added, not masked, into the packed word, so its carry raises the exponent by one. For example, 0x3FB5 × 0x3FB5 gives 0x4000.
- R7: A start seen at a clock edge while idle raises `busy` for exactly 9 cycles. `done` is high for exactly one cycle, the cycle after the last busy cycle, and `busy` is low then.
- R8: A start while `busy` is high is ignored, together with any change of the operand inputs. The pending result belongs to the operands captured at the accepted start.
- R9: `result` changes only in a cycle where `done` is high, and holds its value otherwise.
- R10: After a synchronous active-low reset, `busy` and `done` are 0 and `result` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a multiplication; accepted only while idle |
| op_a | input | 16 | First bfloat16 operand, sampled with an accepted start |
| op_b | input | 16 | Second bfloat16 operand, sampled with an accepted start |
| busy | output | 1 | High while a multiplication is in progress |
| done | output | 1 | One-cycle pulse when a new result is placed on `result` |
| result | output | 16 | bfloat16 product, held until the next done pulse |

## Verification
The assertions check timing and the result sign only. They assume that `start` is a clean synchronous level, and that the operands mean something only in the cycle a start is accepted. The arithmetic assumes normal operands whose exponent sum stays between 128 and 380, so the biased result exponent cannot wrap into the sign bit. The stimulus keeps to this range. Random operands take exponents from 100 to 150, and the directed vectors hit the one-bit shift, the two-bit shift and the rounding carry. The held-start case raises `start` while busy and changes the operand inputs at the same time.

// File: rtl/bf16_mul_pkg.sv
// Package: widths, derived positions and the control state type shared by the
// bfloat16 shift-add multiplier. Assumes a 32-bit working word whose upper half
// holds the bfloat16 layout (sign, exponent, mantissa).
package bf16_mul_pkg;
    localparam int HALF_W  = 16;
    localparam int WORD_W  = 2 * HALF_W;
    localparam int EXP_W   = 8;
    localparam int MAN_W   = HALF_W - 1 - EXP_W;
    localparam int SIG_W   = MAN_W + 1;
    localparam int STEPS   = SIG_W;
    localparam int LATENCY = STEPS + 1;
    localparam int EXP_LSB = WORD_W - 1 - EXP_W;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int CNT_W   = $clog2(STEPS);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HALF_W-1:0] half_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_FIN  = 2'd2
    } mul_state_t;
endpackage

// File: rtl/bf16_operand_align.sv
// Operand aligner: splits one bfloat16 operand into its sign, its exponent
// field left at its 32-bit word position, and its significand with the hidden
// one restored at bit WORD_W-2. Purely combinational; assumes normal operands.
module bf16_operand_align
    import bf16_mul_pkg::*;
(
    input  half_t op,
    output logic  sign,
    output word_t exp_field,
    output word_t sig
);
    // Split the operand into its word-aligned parts.
    always_comb begin
        sign      = op[HALF_W-1];
        exp_field = word_t'(op[HALF_W-2:MAN_W]) << EXP_LSB;
        sig       = word_t'({1'b1, op[MAN_W-1:0]}) << (WORD_W - 1 - SIG_W);
    end
endmodule

// File: rtl/bf16_sign_exp.sv
// Sign/exponent combiner: adds the two word-aligned exponent fields, removes
// one bias and places the XOR of the signs at the top bit. Assumes the
// exponent sum stays in range so the subtraction does not reach the sign bit.
module bf16_sign_exp
    import bf16_mul_pkg::*;
(
    input  logic  sign_a,
    input  logic  sign_b,
    input  word_t exp_a,
    input  word_t exp_b,
    output word_t se_word
);
    localparam word_t BIAS_WORD = word_t'(BIAS) << EXP_LSB;

    // Form the biased result exponent and attach the product sign.
    always_comb begin
        se_word = ((exp_a + exp_b) - BIAS_WORD)
                | {sign_a ^ sign_b, (WORD_W-1)'(0)};
    end
endmodule

// File: rtl/bf16_shift_add_acc.sv
// Shift-add accumulator: on load, stores both aligned significands, clears the
// sum and sets the test mask on the first operand's hidden-one bit. Each step
// adds the current copy of B when A's masked bit is set, then shifts B and the
// mask right by one. The caller runs exactly STEPS steps after a load.
module bf16_shift_add_acc
    import bf16_mul_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  logic  step,
    input  word_t sig_a,
    input  word_t sig_b,
    output word_t acc
);
    localparam word_t MASK_INIT = word_t'(1) << (WORD_W - 2);

    word_t a_q;
    word_t b_q;
    word_t mask_q;
    word_t acc_q;

    // Load the operands, or perform one conditional add and shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            mask_q <= '0;
            acc_q  <= '0;
        end else if (load) begin
            a_q    <= sig_a;
            b_q    <= sig_b;
            mask_q <= MASK_INIT;
            acc_q  <= '0;
        end else if (step) begin
            if (|(a_q & mask_q)) begin
                acc_q <= acc_q + b_q;
            end
            b_q    <= b_q >> 1;
            mask_q <= mask_q >> 1;
        end
    end

    assign acc = acc_q;
endmodule

// File: rtl/bf16_norm_round.sv
// Normaliser/rounder: picks a one-bit or two-bit left shift from the sum's top
// bit and adds one to the exponent on the one-bit path. It rounds the top
// eight bits half-up and adds them below the cleared exponent, so a rounding
// carry reaches the exponent. Combinational.
module bf16_norm_round
    import bf16_mul_pkg::*;
(
    input  word_t acc,
    input  word_t se_word,
    output half_t packed_out
);
    localparam word_t EXP_ONE = word_t'(1) << EXP_LSB;

    word_t            shifted;
    word_t            base;
    word_t            cleared;
    word_t            packed_word;
    logic [SIG_W-1:0] head;
    logic [SIG_W:0]   rnd_sum;
    logic [SIG_W-1:0] rounded;
    logic             unused_low;

    // Normalise, round half-up and pack into the upper half-word.
    always_comb begin
        if (acc[WORD_W-1]) begin
            shifted = acc << 1;
            base    = se_word + EXP_ONE;
        end else begin
            shifted = acc << 2;
            base    = se_word;
        end
        head        = shifted[WORD_W-1 -: SIG_W];
        rnd_sum     = {1'b0, head} + (SIG_W+1)'(1);
        rounded     = rnd_sum[SIG_W:1];
        cleared     = (base >> EXP_LSB) << EXP_LSB;
        packed_word = cleared + (word_t'(rounded) << (EXP_LSB - MAN_W));
        packed_out  = packed_word[WORD_W-1 -: HALF_W];
    end

    assign unused_low = ^{shifted[WORD_W-SIG_W-1:0], rnd_sum[0],
                          packed_word[HALF_W-1:0]};
endmodule

// File: rtl/bf16_shift_add_mul.sv
// Top: sequential bfloat16 multiplier. It accepts start only when idle and
// runs STEPS accumulation cycles plus one normalise/round cycle. It then
// registers the result with a one-cycle done pulse and holds it until the
// next result. Synchronous active-low reset; normal operands assumed.
module bf16_shift_add_mul
    import bf16_mul_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] op_a,
    input  logic [15:0] op_b,
    output logic        busy,
    output logic        done,
    output logic [15:0] result
);
    mul_state_t       state_q;
    logic [CNT_W-1:0] step_q;
    word_t            se_q;
    half_t            result_q;
    logic             done_q;

    logic             load;
    logic             step_en;
    half_t            ops      [2];
    logic             signs    [2];
    word_t            exps     [2];
    word_t            sigs     [2];
    word_t            se_word;
    word_t            acc;
    half_t            packed_res;

    assign ops[0]  = op_a;
    assign ops[1]  = op_b;
    assign load    = start && (state_q == ST_IDLE);
    assign step_en = (state_q == ST_ACC);

    // One aligner per operand.
    for (genvar i = 0; i < 2; i++) begin : g_align
        bf16_operand_align u_align (
            .op        (ops[i]),
            .sign      (signs[i]),
            .exp_field (exps[i]),
            .sig       (sigs[i])
        );
    end

    bf16_sign_exp u_sign_exp (
        .sign_a  (signs[0]),
        .sign_b  (signs[1]),
        .exp_a   (exps[0]),
        .exp_b   (exps[1]),
        .se_word (se_word)
    );

    bf16_shift_add_acc u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step_en),
        .sig_a (sigs[0]),
        .sig_b (sigs[1]),
        .acc   (acc)
    );

    bf16_norm_round u_norm (
        .acc        (acc),
        .se_word    (se_q),
        .packed_out (packed_res)
    );

    // Sequence idle -> accumulate -> finish and register the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            step_q   <= '0;
            se_q     <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        se_q    <= se_word;
                        step_q  <= '0;
                        state_q <= ST_ACC;
                    end
                end
                ST_ACC: begin
                    step_q <= step_q + CNT_W'(1);
                    if (step_q == CNT_W'(STEPS - 1)) begin
                        state_q <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    result_q <= packed_res;
                    done_q   <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (state_q != ST_IDLE);
    assign done   = done_q;
    assign result = result_q;
endmodule

// File: rtl/bf16_mul_chk.sv
// Checker for the bfloat16 multiplier: watches handshake timing, result hold
// and result sign at the top-level ports. The busy window is measured with a
// local counter. Attached by the bind at the end of this file.
module bf16_mul_chk
    import bf16_mul_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [15:0] op_a,
    input logic [15:0] op_b,
    input logic        busy,
    input logic        done,
    input logic [15:0] result
);
    logic [7:0] run_q;
    logic       sign_q;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 8'd1;
        else           run_q <= '0;
    end

    // Remember the expected sign of an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)                sign_q <= 1'b0;
        else if (start && !busy)   sign_q <= op_a[15] ^ op_b[15];
    end

    AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result[15] == sign_q)); // R1
    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_q == 8'(LATENCY - 1)) |=> !busy); // R7
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_q < 8'(LATENCY - 1)) |=> busy); // R8
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && !busy)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result)); // R9
endmodule

bind bf16_shift_add_mul bf16_mul_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op_a   (op_a),
    .op_b   (op_b),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/bf16_shift_add_mul_tb.sv
module bf16_shift_add_mul_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        busy;
    logic        done;
    logic [15:0] result;

    int checks = 0;
    int errors = 0;
    bit compare_on = 0;

    // behavioural model state
    int          m_left = 0;
    bit          m_done = 0;
    logic [15:0] m_res  = '0;
    logic [15:0] m_pend = '0;

    always #2 clk = ~clk;

    bf16_shift_add_mul u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .result(result)
    );

    function automatic logic [15:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
        int sa, sb, p, e, h, r;
        sa = 128 + a[6:0];
        sb = 128 + b[6:0];
        p  = sa * sb;
        e  = int'(a[14:7]) + int'(b[14:7]) - 127;
        if (p >= 32768) begin
            h = (p >> 7) & 255;
            e = e + 1;
        end else begin
            h = (p >> 6) & 255;
        end
        r = (h + 1) >> 1;
        return 16'((int'(a[15] ^ b[15]) << 15) + (e << 7) + r);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Reference model: advances once per clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0; m_done = 0; m_res = '0;
        end else begin
            m_done = 0;
            if (m_left == 0) begin
                if (start) begin
                    m_left = 9;
                    m_pend = ref_mul(op_a, op_b);
                end
            end else begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_done = 1;
                    m_res  = m_pend;
                end
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (compare_on) begin
            check(busy == (m_left != 0), "R7 busy", busy, m_left != 0);
            check(done == m_done, "R7 done", done, m_done);
            check(result == m_res, "R9 result", result, m_res);
        end
    end

    task automatic run_op(input logic [15:0] a, input logic [15:0] b, input string tag);
        int busy_cycles = 0;
        int guard = 0;
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && guard < 40) begin
            if (busy) busy_cycles++;
            guard++;
            @(negedge clk);
        end
        check(busy_cycles == 9, "R7 busy length", busy_cycles, 9);
        check(result == ref_mul(a, b), tag, result, ref_mul(a, b));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R10 busy", busy, 0);
        check(done == 1'b0, "R10 done", done, 0);
        check(result == 16'h0000, "R10 result", result, 0);
        rst_n = 1'b1;
        compare_on = 1;

        run_op(16'h4142, 16'h4236, "R3 vector");
        check(result == 16'h440A, "R3 literal", result, 16'h440A);
        run_op(16'hC142, 16'h4236, "R1 sign");
        check(result == 16'hC40A, "R1 literal", result, 16'hC40A);
        run_op(16'hC142, 16'hC236, "R1 both negative");
        run_op(16'h3F80, 16'h3F80, "R4 unit");
        check(result == 16'h3F80, "R4 literal", result, 16'h3F80);
        run_op(16'h3FB5, 16'h3FB5, "R6 carry");
        check(result == 16'h4000, "R6 literal", result, 16'h4000);
        run_op(16'h4000, 16'h4040, "R2 exponent");
        check(result == 16'h40C0, "R2 literal", result, 16'h40C0);
        run_op(16'h3FFF, 16'h3FFF, "R5 rounding");

        // R8: start held while busy with changing operands is ignored.
        @(negedge clk);
        op_a = 16'h4142; op_b = 16'h4236; start = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            op_a = 16'h3F80 + 16'(i); op_b = 16'hC000;
        end
        start = 1'b0;
        for (int i = 0; i < 20 && !done; i++) @(negedge clk);
        check(result == 16'h440A, "R8 ignored start", result, 16'h440A);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R8 idle after", busy, 0);

        for (int i = 0; i < 40; i++) begin
            logic [15:0] a, b;
            a = {1'($urandom % 2), 8'(100 + $urandom % 51), 7'($urandom % 128)};
            b = {1'($urandom % 2), 8'(100 + $urandom % 51), 7'($urandom % 128)};
            run_op(a, b, "R5 random");
            if ((i % 5) == 0) repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule